// File: doc/BRIEF.md
# Type-C Port Controller Alert and Fault Status Block

This block collects event pulses from a USB Type-C port controller into one sticky alert register and drives a single active-low interrupt line toward the host. Each event source owns one alert bit. The host reads pending alerts through a byte-wide register port and acknowledges them by writing ones. A per-bit alert mask decides which pending bits pull the interrupt low.

The block also records fault conditions in a sticky fault status register. A sink-side VBUS presence input feeds a power-status view, and a power-status mask decides whether a VBUS change raises the power alert. Recorded faults are cleared only through a self-clearing command bit. The fault alert cannot be acknowledged while any fault is still recorded.

The interrupt line is produced by a two-state machine. In IRQ_IDLE the line is high. The transition IDLE→RAISED happens at the clock edge where the next alert-and-mask value becomes nonzero. The transition RAISED→IDLE happens at the edge where that value returns to zero.

Top module: `tcpc_alert_regs`

## Requirements
- R1: After reset, the alert register is 0x0000, the alert mask is 0x0FFF, the power-status mask is 0xFF, the fault status is 0x00 and `alert_n_o` is high.
- R2: A one on `evt_i[k]` at a clock edge sets alert bit k from that edge onward. The bit positions are: 0 CC change, 1 power change, 2 receive, 3 hard reset received, 4 transmit failed, 5 transmit discarded, 6 transmit done, 7 voltage high alarm, 8 voltage low alarm, 9 fault, 10 receive overflow, 11 sink disconnect.
- R3: Alert bits are write-one-to-clear, little-endian. A write to 0x10 clears the bits set in the data among bits 7:0. A write to 0x11 does the same for bits 15:8. Zero data bits leave the register unchanged.
- R4: When an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R5: Alert bits 15:12 always read as zero, including after events and writes.
- R6: The 16-bit alert mask is read/write. Its low byte is at 0x12 and its high byte at 0x13.
- R7: `alert_n_o` is low in exactly the cycles where (alert AND mask) is nonzero. It changes at the same edge as the alert or mask register.
- R8: The 8-bit power-status mask at 0x14 is read/write.
- R9: A read of 0x1E returns the VBUS-present input in bit 2 and zeros in all other bits.
- R10: A change of `vbus_present_i` sets alert bit 1 only while bit 2 of the power-status mask is one.
- R11: A one on `fault_evt_i[j]` sets fault status bit j (bits 6:0, at 0x1F) and also sets alert bit 9.
- R12: A write to 0x1F with data bit 7 set clears all recorded faults. Writes without bit 7 change nothing. Bit 7 of a read of 0x1F is always 0. A fault event in the same cycle as the clear stays recorded.
- R13: A clearing write to alert bit 9 has no effect while any fault status bit is set.
- R14: A read strobe returns the addressed byte on `reg_rdata_o` one cycle later, with the value held before that edge. Unmapped addresses read 0. The output holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 12 | Event pulses, one per alert bit |
| fault_evt_i | input | 7 | Fault condition pulses |
| vbus_present_i | input | 1 | VBUS present level |
| reg_addr_i | input | 8 | Register byte address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, registered |
| alert_n_o | output | 1 | Active-low interrupt |

## Verification
The embedded assertions check the following on every cycle:
- the set-over-clear priority and the clearing of acknowledged bits;
- the fault clear command;
- the rule that the fault alert is held while faults remain;
- the agreement between the interrupt state machine and the masked alert value.

Some behaviour only the bench scenarios can show:
- the byte lanes;
- the reset values;
- the VBUS-change gating by the power-status mask;
- the read-back of unmapped addresses.

A behavioural model in the bench compares the interrupt line and every read on each clock.

// File: rtl/tcpc_alert_pkg.sv
package tcpc_alert_pkg;
    parameter int ALERT_W   = 16;
    parameter int ALERT_USE = 12;
    parameter int FAULT_W   = 7;

    parameter logic [7:0] A_ALERT_LO = 8'h10;
    parameter logic [7:0] A_ALERT_HI = 8'h11;
    parameter logic [7:0] A_MASK_LO  = 8'h12;
    parameter logic [7:0] A_MASK_HI  = 8'h13;
    parameter logic [7:0] A_PWR_MASK = 8'h14;
    parameter logic [7:0] A_PWR_STAT = 8'h1E;
    parameter logic [7:0] A_FAULT    = 8'h1F;

    parameter int BIT_POWER = 1;
    parameter int BIT_FAULT = 9;
    parameter int VBUS_BIT  = 2;
    parameter int FCLR_BIT  = 7;

    parameter logic [15:0] MASK_RST = 16'h0FFF;
    parameter logic [7:0]  PMSK_RST = 8'hFF;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/tcpc_alert_bank.sv
module tcpc_alert_bank #(
    parameter int W = tcpc_alert_pkg::ALERT_W,
    parameter int U = tcpc_alert_pkg::ALERT_USE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [U-1:0] set_i,
    input  logic [U-1:0] clr_i,
    output logic [W-1:0] alert_o,
    output logic [W-1:0] alert_nxt_o
);
    logic [U-1:0] bits_q;
    logic [U-1:0] bits_d;

    for (genvar k = 0; k < W; k++) begin : g_bit
        if (k < U) begin : g_live
            assign bits_d[k]      = set_i[k] | (bits_q[k] & ~clr_i[k]);
            assign alert_o[k]     = bits_q[k];
            assign alert_nxt_o[k] = bits_d[k];
        end else begin : g_pad
            assign alert_o[k]     = 1'b0;
            assign alert_nxt_o[k] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    // R4
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((bits_q & $past(set_i)) == $past(set_i)));

    // R3
    clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((bits_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/tcpc_fault_log.sv
module tcpc_fault_log #(
    parameter int FW = tcpc_alert_pkg::FAULT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] fevt_i,
    input  logic          clr_i,
    output logic [FW-1:0] fault_o,
    output logic          any_o
);
    logic [FW-1:0] fault_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     fault_q <= '0;
        else if (clr_i) fault_q <= fevt_i;
        else            fault_q <= fault_q | fevt_i;
    end

    assign fault_o = fault_q;
    assign any_o   = |fault_q;

    // R12
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && fevt_i == '0) |=> (fault_q == '0));
endmodule

// File: rtl/tcpc_irq_fsm.sv
module tcpc_irq_fsm
    import tcpc_alert_pkg::*;
#(
    parameter int W = ALERT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] alert_nxt_i,
    input  logic [W-1:0] mask_nxt_i,
    input  logic [W-1:0] alert_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_n_o
);
    irq_state_t state_q, state_d;
    logic       hit;

    assign hit = |(alert_nxt_i & mask_nxt_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (hit)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!hit) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n_o = (state_q != IRQ_RAISED);
    end

    // R7
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o == ((alert_i & mask_i) == '0));
endmodule

// File: rtl/tcpc_alert_regs.sv
module tcpc_alert_regs
    import tcpc_alert_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] evt_i,
    input  logic [6:0]  fault_evt_i,
    input  logic        vbus_present_i,
    input  logic [7:0]  reg_addr_i,
    input  logic        reg_wr_i,
    input  logic        reg_rd_i,
    input  logic [7:0]  reg_wdata_i,
    output logic [7:0]  reg_rdata_o,
    output logic        alert_n_o
);
    localparam int HI_W = ALERT_USE - 8;

    logic [ALERT_W-1:0]   alert_q, alert_nxt;
    logic [ALERT_W-1:0]   mask_q, mask_d;
    logic [7:0]           pmask_q, pmask_d;
    logic [ALERT_USE-1:0] set_v, clr_v;
    logic [FAULT_W-1:0]   fault_q;
    logic                 fault_any, fault_clr;
    logic                 vbus_prev_q, vbus_chg;
    logic [7:0]           rd_mux, rdata_q;

    assign vbus_chg = vbus_present_i ^ vbus_prev_q;

    always_comb begin
        set_v            = evt_i;
        set_v[BIT_POWER] = evt_i[BIT_POWER] | (vbus_chg & pmask_q[VBUS_BIT]);
        set_v[BIT_FAULT] = evt_i[BIT_FAULT] | (|fault_evt_i);
    end

    always_comb begin
        clr_v = '0;
        if (reg_wr_i && reg_addr_i == A_ALERT_LO) clr_v[7:0] = reg_wdata_i;
        if (reg_wr_i && reg_addr_i == A_ALERT_HI) clr_v[ALERT_USE-1:8] = reg_wdata_i[HI_W-1:0];
        if (fault_any) clr_v[BIT_FAULT] = 1'b0;
    end

    always_comb begin
        mask_d  = mask_q;
        pmask_d = pmask_q;
        if (reg_wr_i) begin
            unique case (reg_addr_i)
                A_MASK_LO:  mask_d[7:0]  = reg_wdata_i;
                A_MASK_HI:  mask_d[15:8] = reg_wdata_i;
                A_PWR_MASK: pmask_d      = reg_wdata_i;
                default:    ;
            endcase
        end
    end

    assign fault_clr = reg_wr_i && reg_addr_i == A_FAULT && reg_wdata_i[FCLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q      <= MASK_RST;
            pmask_q     <= PMSK_RST;
            vbus_prev_q <= 1'b0;
        end else begin
            mask_q      <= mask_d;
            pmask_q     <= pmask_d;
            vbus_prev_q <= vbus_present_i;
        end
    end

    tcpc_alert_bank #(.W(ALERT_W), .U(ALERT_USE)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v),
        .alert_o(alert_q), .alert_nxt_o(alert_nxt)
    );

    tcpc_fault_log #(.FW(FAULT_W)) u_fault (
        .clk(clk), .rst_n(rst_n), .fevt_i(fault_evt_i), .clr_i(fault_clr),
        .fault_o(fault_q), .any_o(fault_any)
    );

    tcpc_irq_fsm #(.W(ALERT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .alert_nxt_i(alert_nxt), .mask_nxt_i(mask_d),
        .alert_i(alert_q), .mask_i(mask_q), .irq_n_o(alert_n_o)
    );

    always_comb begin
        unique case (reg_addr_i)
            A_ALERT_LO: rd_mux = alert_q[7:0];
            A_ALERT_HI: rd_mux = alert_q[15:8];
            A_MASK_LO:  rd_mux = mask_q[7:0];
            A_MASK_HI:  rd_mux = mask_q[15:8];
            A_PWR_MASK: rd_mux = pmask_q;
            A_PWR_STAT: rd_mux = 8'(vbus_present_i) << VBUS_BIT;
            A_FAULT:    rd_mux = {1'b0, fault_q};
            default:    rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rdata_q <= 8'h00;
        else if (reg_rd_i) rdata_q <= rd_mux;
    end
    assign reg_rdata_o = rdata_q;

    // R13
    fault_alert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_any && alert_q[BIT_FAULT]) |=> alert_q[BIT_FAULT]);

    // R5
    upper_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == A_ALERT_HI) |=> (alert_q[15:12] == 4'h0));
endmodule

// File: tb/tcpc_alert_regs_tb.sv
`timescale 1ns/1ps
module tcpc_alert_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt = '0;
    logic [6:0]  fevt = '0;
    logic        vbus = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq_n;

    int vectors = 0;
    int errors  = 0;

    logic [15:0] m_alert, m_mask;
    logic [7:0]  m_pmask, m_rdata;
    logic [6:0]  m_fault;
    logic        m_vprev;

    always #2.5 clk = ~clk;

    tcpc_alert_regs dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .fault_evt_i(fevt),
        .vbus_present_i(vbus), .reg_addr_i(addr), .reg_wr_i(wr),
        .reg_rd_i(rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .alert_n_o(irq_n)
    );

    function automatic logic [7:0] model_read(input logic [7:0] a);
        case (a)
            8'h10: return m_alert[7:0];
            8'h11: return m_alert[15:8];
            8'h12: return m_mask[7:0];
            8'h13: return m_mask[15:8];
            8'h14: return m_pmask;
            8'h1E: return {5'b0, vbus, 2'b0};
            8'h1F: return {1'b0, m_fault};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input string req);
        logic [15:0] set, clr;
        logic        chg;
        @(posedge clk);
        if (rd) m_rdata = model_read(addr);
        chg = (vbus != m_vprev);
        m_vprev = vbus;
        set = {4'b0, evt};
        if (chg && m_pmask[2]) set[1] = 1'b1;
        if (fevt != 0) set[9] = 1'b1;
        clr = '0;
        if (wr && addr == 8'h10) clr[7:0] = wdata;
        if (wr && addr == 8'h11) clr[15:8] = wdata;
        if (m_fault != 0) clr[9] = 1'b0;
        m_alert = ((m_alert & ~clr) | set) & 16'h0FFF;
        if (wr && addr == 8'h12) m_mask[7:0] = wdata;
        if (wr && addr == 8'h13) m_mask[15:8] = wdata;
        if (wr && addr == 8'h14) m_pmask = wdata;
        if (wr && addr == 8'h1F && wdata[7]) m_fault = '0;
        m_fault = m_fault | fevt;
        #1;
        check(req, "alert_n", int'(irq_n), int'((m_alert & m_mask) == 0));
        check(req, "rdata", int'(rdata), int'(m_rdata));
        wr = 1'b0; rd = 1'b0; evt = '0; fevt = '0;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d, input string req);
        addr = a; wdata = d; wr = 1'b1;
        step(req);
    endtask

    task automatic rreg(input logic [7:0] a, input logic [7:0] exp, input string req);
        addr = a; rd = 1'b1;
        step(req);
        check(req, "read value", int'(rdata), int'(exp));
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        m_alert = '0; m_mask = 16'h0FFF; m_pmask = 8'hFF; m_fault = '0;
        m_vprev = 1'b0; m_rdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1", "reset alert_n", int'(irq_n), 1);
        check("R1", "reset rdata", int'(rdata), 0);

        // R1 R14 reset values read back
        rreg(8'h10, 8'h00, "R1");
        rreg(8'h12, 8'hFF, "R1");
        rreg(8'h13, 8'h0F, "R1");
        rreg(8'h14, 8'hFF, "R8");
        rreg(8'h1F, 8'h00, "R1");

        // R2 R7 single event raises interrupt
        evt = 12'h001; step("R2");
        check("R7", "irq after event", int'(irq_n), 0);
        rreg(8'h10, 8'h01, "R2");
        // R3 zero write keeps, one write clears
        wreg(8'h10, 8'h00, "R3");
        rreg(8'h10, 8'h01, "R3");
        wreg(8'h10, 8'h01, "R3");
        check("R7", "irq after clear", int'(irq_n), 1);

        // R2 R5 all events, then high byte clear
        evt = 12'hFFF; step("R2");
        rreg(8'h11, 8'h0F, "R5");
        wreg(8'h11, 8'hFF, "R5");
        rreg(8'h11, 8'h00, "R5");
        rreg(8'h10, 8'hFF, "R3");
        wreg(8'h10, 8'hFF, "R3");
        rreg(8'h10, 8'h00, "R3");

        // R4 event beats clear
        evt = 12'h010; addr = 8'h10; wdata = 8'h10; wr = 1'b1; step("R4");
        rreg(8'h10, 8'h10, "R4");
        wreg(8'h10, 8'h10, "R4");

        // R6 R7 mask behaviour
        wreg(8'h12, 8'h00, "R6");
        wreg(8'h13, 8'hA0, "R6");
        rreg(8'h13, 8'hA0, "R6");
        evt = 12'h008; step("R7");
        check("R7", "masked irq", int'(irq_n), 1);
        wreg(8'h12, 8'h08, "R6");
        check("R7", "unmasked irq", int'(irq_n), 0);
        wreg(8'h10, 8'h08, "R7");
        wreg(8'h13, 8'h0F, "R6");

        // R9 R10 vbus change gated by power mask
        vbus = 1'b1; step("R10");
        rreg(8'h10, 8'h02, "R10");
        rreg(8'h1E, 8'h04, "R9");
        wreg(8'h10, 8'h02, "R10");
        wreg(8'h14, 8'h00, "R8");
        vbus = 1'b0; step("R10");
        rreg(8'h10, 8'h00, "R10");
        rreg(8'h1E, 8'h00, "R9");

        // R11 R12 R13 fault path
        fevt = 7'h05; step("R11");
        rreg(8'h1F, 8'h05, "R11");
        rreg(8'h11, 8'h02, "R11");
        wreg(8'h11, 8'h02, "R13");
        rreg(8'h11, 8'h02, "R13");
        wreg(8'h1F, 8'h7F, "R12");
        rreg(8'h1F, 8'h05, "R12");
        addr = 8'h1F; wdata = 8'h80; wr = 1'b1; fevt = 7'h40; step("R12");
        rreg(8'h1F, 8'h40, "R12");
        wreg(8'h1F, 8'hFF, "R12");
        rreg(8'h1F, 8'h00, "R12");
        wreg(8'h11, 8'h02, "R13");
        rreg(8'h11, 8'h00, "R13");
        check("R7", "irq idle at end", int'(irq_n), 1);

        // R14 unmapped address and hold
        rreg(8'h20, 8'h00, "R14");
        step("R14");
        check("R14", "rdata hold", int'(rdata), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule